// File: doc/BRIEF.md
# Scatter-Gather DMA Descriptor Engine

This block is a single-channel DMA engine driven through a small word-addressed register port. Software programs the location of a descriptor table, the location of a 128-byte completion area and a transfer direction, then raises the start bit. The engine walks the table, one 16-byte descriptor at a time, over a simple word-wide memory port. For each descriptor it moves the described buffer, one 32-bit word per step, between memory and a device-side word stream.

The table is walked until a descriptor carrying the last-entry flag has been fully transferred. The engine then fills the completion area with all-ones words, so that software can poll memory to learn that every data write has landed. A stop request from software halts the engine at the next safe point. The stop bit stays visible until the halt has happened. Device-side and memory-side byte totals are counted separately, so software can compare them afterwards.

Top module: `sgdma_engine`

## Requirements
- R1: After reset every register reads 0, the engine is idle, and no memory request, device ready or device valid is raised.
- R2: Register word offsets: 0 timing (read/write storage), 1 table pointer low, 2 table pointer high, 8 completion address (all read/write); 3 current buffer address (read-only), 4 reads 0, 5 device byte count and 6 memory byte count (read-only), 7 control; unmapped offsets read 0. Control bits: 0 start (write-only, reads 0), 1 stop, 2 direction, 3 active (read-only), 4 error (read-only).
- R3: A descriptor is fetched as four word reads at table address +0, +4, +8, +12, in that order; the next descriptor follows 16 bytes later. Each word is big-endian. Word 1 holds the buffer byte address. Word 3 holds the byte length in bits 15:0 and the last-entry flag in bit 31. A memory request holds address, write enable and write data until it is acknowledged.
- R4: With direction 1, each word taken from the device stream is written to memory at consecutive word addresses starting at the descriptor's buffer address.
- R5: With direction 0, buffer words are read from memory at consecutive word addresses and presented on the device stream in order.
- R6: After the last data word of a descriptor flagged as the last entry, the engine writes 32 words of 0xFFFFFFFF to completion address +4*i (i = 0..31), then clears active.
- R7: Both byte counters clear on an accepted start. The device counter grows at each device handshake, the memory counter at each acknowledged data access; each step is 4 bytes except the final word of a buffer, which adds the remaining 1 to 4 bytes.
- R8: A length field of 0 transfers 65536 bytes.
- R9: Writing control with bit 1 set makes the stop bit read 1 while the engine is active; the engine halts at its next device wait or memory acknowledge without writing the completion area, active clears, and the stop bit reads 0 one cycle later.
- R10: An error response on a memory request sets the error bit and clears active; the completion area is not written.
- R11: A start while the error bit is set, while active, or in the same write as stop, is ignored; the error bit clears only when a stop is processed while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on reg_addr_i) |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge, completes the request |
| mem_err_i | input | 1 | Memory error response |
| mem_rdata_i | input | 32 | Memory read data, valid with acknowledge |
| rx_valid_i | input | 1 | Device-to-memory word valid |
| rx_data_i | input | 32 | Device-to-memory word |
| rx_ready_o | output | 1 | Engine accepts a device word |
| tx_valid_o | output | 1 | Memory-to-device word valid |
| tx_data_o | output | 32 | Memory-to-device word |
| tx_ready_i | input | 1 | Device accepts the word |

## Verification
On every cycle the assertions check that a memory request stays stable until answered, that the memory port and the two stream handshakes are never driven together, that an idle engine drives none of them, that an error response halts the engine with the error bit set, that the error bit persists until a stop, and that a stop seen while idle releases on the next cycle. Only the bench scenarios show data content and ordering: big-endian descriptor decode, the address sequence of table walking, buffer data in both directions, the 32-word completion fill, the partial-word byte counts, the zero-length buffer of 65536 bytes, and the cycle-exact readback of the stop bit.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  localparam logic [3:0] OFF_TIMING  = 4'd0;
  localparam logic [3:0] OFF_TBL_LO  = 4'd1;
  localparam logic [3:0] OFF_TBL_HI  = 4'd2;
  localparam logic [3:0] OFF_CUR_LO  = 4'd3;
  localparam logic [3:0] OFF_CUR_HI  = 4'd4;
  localparam logic [3:0] OFF_DEV_CNT = 4'd5;
  localparam logic [3:0] OFF_MEM_CNT = 4'd6;
  localparam logic [3:0] OFF_CTRL    = 4'd7;
  localparam logic [3:0] OFF_END     = 4'd8;

  localparam int unsigned CB_START = 0;
  localparam int unsigned CB_STOP  = 1;
  localparam int unsigned CB_DIR   = 2;
  localparam int unsigned CB_ACT   = 3;
  localparam int unsigned CB_ERR   = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_RX, ST_WR, ST_RD, ST_TX, ST_FLAG
  } state_e;

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/sgdma_bcnt.sv
module sgdma_bcnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [2:0]       step_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + CNT_W'(step_i);
  end
endmodule

// File: rtl/sgdma_regs.sv
module sgdma_regs
  import sgdma_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [3:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic             active_i,
  input  logic             err_i,
  input  logic [31:0]      cur_addr_i,
  input  logic [CNT_W-1:0] dev_cnt_i,
  input  logic [CNT_W-1:0] mem_cnt_i,
  output logic [31:0]      tbl_ptr_o,
  output logic [31:0]      end_addr_o,
  output logic             dir_o,
  output logic             start_o,
  output logic             stop_req_o
);
  logic [31:0] timing_q, tbl_hi_q;
  logic        ctrl_wr;

  assign ctrl_wr = we_i && (addr_i == OFF_CTRL);
  // stop in the same write wins over start
  assign start_o = ctrl_wr && wdata_i[CB_START] && !wdata_i[CB_STOP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timing_q   <= '0;
      tbl_ptr_o  <= '0;
      tbl_hi_q   <= '0;
      end_addr_o <= '0;
      dir_o      <= 1'b0;
      stop_req_o <= 1'b0;
    end else begin
      if (we_i) begin
        unique case (addr_i)
          OFF_TIMING: timing_q   <= wdata_i;
          OFF_TBL_LO: tbl_ptr_o  <= wdata_i;
          OFF_TBL_HI: tbl_hi_q   <= wdata_i;
          OFF_END:    end_addr_o <= wdata_i;
          default: ;
        endcase
      end
      if (ctrl_wr && !active_i) dir_o <= wdata_i[CB_DIR];
      // held until the engine is seen idle
      if (ctrl_wr && wdata_i[CB_STOP]) stop_req_o <= 1'b1;
      else if (!active_i)              stop_req_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_TIMING:  rdata_o = timing_q;
      OFF_TBL_LO:  rdata_o = tbl_ptr_o;
      OFF_TBL_HI:  rdata_o = tbl_hi_q;
      OFF_CUR_LO:  rdata_o = cur_addr_i;
      OFF_CUR_HI:  rdata_o = '0;
      OFF_DEV_CNT: rdata_o = 32'(dev_cnt_i);
      OFF_MEM_CNT: rdata_o = 32'(mem_cnt_i);
      OFF_END:     rdata_o = end_addr_o;
      OFF_CTRL: begin
        rdata_o[CB_STOP] = stop_req_o;
        rdata_o[CB_DIR]  = dir_o;
        rdata_o[CB_ACT]  = active_i;
        rdata_o[CB_ERR]  = err_i;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sgdma_fsm.sv
module sgdma_fsm
  import sgdma_pkg::*;
#(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned END_WORDS = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic        dir_i,
  input  logic [31:0] tbl_ptr_i,
  input  logic [31:0] end_addr_i,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_ack_i,
  input  logic        mem_err_i,
  input  logic [31:0] mem_rdata_i,
  input  logic        rx_valid_i,
  input  logic [31:0] rx_data_i,
  output logic        rx_ready_o,
  output logic        tx_valid_o,
  output logic [31:0] tx_data_o,
  input  logic        tx_ready_i,
  output logic        active_o,
  output logic        err_o,
  output logic [31:0] cur_addr_o,
  output logic        cnt_clr_o,
  output logic        dev_inc_o,
  output logic        mem_inc_o,
  output logic [2:0]  step_o
);
  localparam int unsigned REM_W = LEN_W + 1;
  localparam int unsigned EW    = (END_WORDS > 1) ? $clog2(END_WORDS) : 1;

  state_e           state_q;
  logic [31:0]      dptr_q, buf_q;
  logic [1:0]       wi_q;
  logic [EW-1:0]    fidx_q;
  logic [REM_W-1:0] rem_q;
  logic             eol_q;

  logic [31:0] desc_w;
  logic        mem_ok, mem_bad, last, rx_hs, tx_hs, start_ok;
  state_e      after_word;
  logic        unused_desc;

  assign desc_w      = bswap(mem_rdata_i);
  assign unused_desc = ^desc_w[30:LEN_W];

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = cur_addr_o;
    mem_wdata_o = buf_q;
    unique case (state_q)
      ST_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = dptr_q + 32'({wi_q, 2'b00});
      end
      ST_WR: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
      end
      ST_RD: mem_req_o = 1'b1;
      ST_FLAG: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = end_addr_i + 32'({fidx_q, 2'b00});
        mem_wdata_o = '1;
      end
      default: ;
    endcase
  end

  assign mem_ok     = mem_req_o && mem_ack_i && !mem_err_i;
  assign mem_bad    = mem_req_o && mem_err_i;
  assign last       = (rem_q <= REM_W'(4));
  assign step_o     = last ? rem_q[2:0] : 3'd4;
  assign rx_ready_o = (state_q == ST_RX) && !stop_i;
  assign tx_valid_o = (state_q == ST_TX) && !stop_i;
  assign tx_data_o  = buf_q;
  assign rx_hs      = rx_ready_o && rx_valid_i;
  assign tx_hs      = tx_valid_o && tx_ready_i;
  assign dev_inc_o  = rx_hs || tx_hs;
  assign mem_inc_o  = mem_ok && ((state_q == ST_WR) || (state_q == ST_RD));
  assign start_ok   = (state_q == ST_IDLE) && start_i && !err_o && !stop_i;
  assign cnt_clr_o  = start_ok;
  assign active_o   = (state_q != ST_IDLE);
  assign after_word = last ? (eol_q ? ST_FLAG : ST_FETCH) : (dir_i ? ST_RX : ST_RD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      dptr_q     <= '0;
      buf_q      <= '0;
      wi_q       <= '0;
      fidx_q     <= '0;
      rem_q      <= '0;
      eol_q      <= 1'b0;
      err_o      <= 1'b0;
      cur_addr_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (stop_i) err_o <= 1'b0;
          if (start_ok) begin
            dptr_q  <= tbl_ptr_i;
            wi_q    <= '0;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_bad) begin
            err_o   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (mem_ok) begin
            wi_q <= wi_q + 2'd1;
            if (wi_q == 2'd1) cur_addr_o <= desc_w;
            if (wi_q == 2'd3) begin
              rem_q  <= (desc_w[LEN_W-1:0] == '0) ? REM_W'(1) << LEN_W
                                                  : REM_W'(desc_w[LEN_W-1:0]);
              eol_q  <= desc_w[31];
              dptr_q <= dptr_q + 32'd16;
            end
            if (stop_i)              state_q <= ST_IDLE;
            else if (wi_q == 2'd3)   state_q <= dir_i ? ST_RX : ST_RD;
          end
        end
        ST_RX: begin
          if (stop_i) state_q <= ST_IDLE;
          else if (rx_hs) begin
            buf_q   <= rx_data_i;
            state_q <= ST_WR;
          end
        end
        ST_RD: begin
          if (mem_bad) begin
            err_o   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (mem_ok) begin
            buf_q   <= mem_rdata_i;
            state_q <= stop_i ? ST_IDLE : ST_TX;
          end
        end
        ST_WR, ST_TX: begin
          if (mem_bad) begin
            err_o   <= 1'b1;
            state_q <= ST_IDLE;
          end else if ((state_q == ST_TX) && stop_i) begin
            state_q <= ST_IDLE;
          end else if (mem_ok || tx_hs) begin
            cur_addr_o <= cur_addr_o + 32'd4;
            rem_q      <= rem_q - REM_W'(step_o);
            wi_q       <= '0;
            fidx_q     <= '0;
            state_q    <= stop_i ? ST_IDLE : after_word;
          end
        end
        ST_FLAG: begin
          if (mem_bad) begin
            err_o   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (mem_ok) begin
            fidx_q <= fidx_q + EW'(1);
            if (stop_i || (fidx_q == EW'(END_WORDS - 1))) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
  import sgdma_pkg::*;
#(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned END_WORDS = 32,
  parameter int unsigned CNT_W     = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [3:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_ack_i,
  input  logic        mem_err_i,
  input  logic [31:0] mem_rdata_i,
  input  logic        rx_valid_i,
  input  logic [31:0] rx_data_i,
  output logic        rx_ready_o,
  output logic        tx_valid_o,
  output logic [31:0] tx_data_o,
  input  logic        tx_ready_i
);
  logic             active, err, stop_req, start, dir, cnt_clr;
  logic [31:0]      tbl_ptr, end_addr, cur_addr;
  logic [2:0]       step;
  logic [1:0]       inc;
  logic [CNT_W-1:0] cnt [2];

  sgdma_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .active_i   (active),
    .err_i      (err),
    .cur_addr_i (cur_addr),
    .dev_cnt_i  (cnt[0]),
    .mem_cnt_i  (cnt[1]),
    .tbl_ptr_o  (tbl_ptr),
    .end_addr_o (end_addr),
    .dir_o      (dir),
    .start_o    (start),
    .stop_req_o (stop_req)
  );

  sgdma_fsm #(.LEN_W(LEN_W), .END_WORDS(END_WORDS)) u_fsm (
    .clk_i, .rst_ni,
    .start_i    (start),
    .stop_i     (stop_req),
    .dir_i      (dir),
    .tbl_ptr_i  (tbl_ptr),
    .end_addr_i (end_addr),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_ack_i, .mem_err_i, .mem_rdata_i,
    .rx_valid_i, .rx_data_i, .rx_ready_o,
    .tx_valid_o, .tx_data_o, .tx_ready_i,
    .active_o   (active),
    .err_o      (err),
    .cur_addr_o (cur_addr),
    .cnt_clr_o  (cnt_clr),
    .dev_inc_o  (inc[0]),
    .mem_inc_o  (inc[1]),
    .step_o     (step)
  );

  // index 0: device side, index 1: memory side
  for (genvar g = 0; g < 2; g++) begin : g_cnt
    sgdma_bcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i, .rst_ni,
      .clr_i  (cnt_clr),
      .inc_i  (inc[g]),
      .step_i (step),
      .cnt_o  (cnt[g])
    );
  end
endmodule

// File: rtl/sgdma_chk.sv
module sgdma_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_i,
  input logic        mem_we_i,
  input logic [31:0] mem_addr_i,
  input logic [31:0] mem_wdata_i,
  input logic        mem_ack_i,
  input logic        mem_err_i,
  input logic        rx_ready_i,
  input logic        tx_valid_i,
  input logic        active_i,
  input logic        err_i,
  input logic        stop_req_i
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> !mem_req_i && !rx_ready_i && !tx_valid_i);

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_ack_i && !mem_err_i |=>
      mem_req_i && $stable(mem_addr_i) && $stable(mem_we_i) && $stable(mem_wdata_i));

  // R4 and R5: one port in use at a time
  assert_one_port_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_req_i, rx_ready_i, tx_valid_i}));

  assert_stop_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_req_i && !active_i |=> !stop_req_i);

  assert_err_halt_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && mem_err_i |=> !active_i && err_i);

  assert_err_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i && !stop_req_i |=> err_i);

  assert_err_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> !active_i);
endmodule

bind sgdma_engine sgdma_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_req_i  (mem_req_o),
  .mem_we_i   (mem_we_o),
  .mem_addr_i (mem_addr_o),
  .mem_wdata_i(mem_wdata_o),
  .mem_ack_i  (mem_ack_i),
  .mem_err_i  (mem_err_i),
  .rx_ready_i (rx_ready_o),
  .tx_valid_i (tx_valid_o),
  .active_i   (active),
  .err_i      (err),
  .stop_req_i (stop_req)
);

// File: tb/tb_sgdma_engine.sv
`timescale 1ns/1ps
module tb_sgdma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        rx_valid = 1'b1;
  logic [31:0] rx_data;
  logic        rx_ready, tx_valid;
  logic [31:0] tx_data;
  logic        tx_ready = 1'b1;

  always #2 clk = ~clk;

  sgdma_engine dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_err_i(mem_err), .mem_rdata_i(mem_rdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready)
  );

  // memory model: descriptor table at 0x1000, data = address ^ 0x5A5A0000
  logic [31:0] tbl [16];
  logic        ack_tog = 1'b0;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;
  always @(negedge clk) ack_tog <= ~ack_tog;
  assign mem_ack   = mem_req && ack_tog;
  assign mem_err   = mem_req && err_en && (mem_addr == err_addr);
  assign mem_rdata = (mem_addr[31:6] == 26'h40) ? tbl[mem_addr[5:2]] : (mem_addr ^ 32'h5A5A_0000);

  int rx_idx = 0;
  assign rx_data = 32'hC0DE_0000 + rx_idx;

  logic [31:0] wa [64], wd [64], ra [64], td [64];
  int wn = 0, rn = 0, tn = 0, cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (mem_req && mem_ack && !mem_err) begin
      if (mem_we) begin
        if (wn < 64) begin wa[wn] = mem_addr; wd[wn] = mem_wdata; end
        wn++;
      end else begin
        if (rn < 64) ra[rn] = mem_addr;
        rn++;
      end
    end
    if (tx_valid && tx_ready) begin
      if (tn < 64) td[tn] = tx_data;
      tn++;
    end
    if (rx_valid && rx_ready) rx_idx <= rx_idx + 1;
  end

  int vec_n = 0, miss_n = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec_n++;
    if (act !== exp) begin
      miss_n++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle(input int lim, input string tag);
    logic [31:0] v;
    for (int k = 0; k < lim; k++) begin
      reg_rd(4'd7, v);
      if (!v[3]) return;
      @(negedge clk);
    end
    chk(tag, 32'd1, 32'd0);
  endtask

  function automatic logic [31:0] bsw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic set_desc(input int i, input logic [31:0] a, input logic [15:0] len, input logic eol);
    tbl[4*i]   = '0;
    tbl[4*i+1] = bsw(a);
    tbl[4*i+2] = '0;
    tbl[4*i+3] = bsw({eol, 15'd0, len});
  endtask

  task automatic clear_logs(output int rb);
    wn = 0; rn = 0; tn = 0; rb = rx_idx;
  endtask

  // {offset, write data, expected readback}
  localparam logic [67:0] VEC [9] = '{
    {4'd0, 32'h0000_A5C3, 32'h0000_A5C3},
    {4'd1, 32'h0000_1000, 32'h0000_1000},
    {4'd2, 32'hDEAD_0001, 32'hDEAD_0001},
    {4'd8, 32'h0000_4000, 32'h0000_4000},
    {4'd3, 32'h0000_FFFF, 32'h0000_0000},
    {4'd4, 32'h0000_FFFF, 32'h0000_0000},
    {4'd5, 32'h0000_0055, 32'h0000_0000},
    {4'd7, 32'h0000_0004, 32'h0000_0004},
    {4'd9, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  initial begin
    while (cyc < 190000) @(posedge clk);
    miss_n++;
    $display("FAIL watchdog all actual=%0d expected=<190000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int rb;
    for (int i = 0; i < 16; i++) tbl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 9; a++) begin
      reg_rd(4'(a), v);
      chk("R1 reset register", v, 32'd0);
    end
    chk("R1 no request", {31'd0, mem_req}, 32'd0);

    // R2 register map walk
    for (int i = 0; i < 9; i++) begin
      reg_wr(VEC[i][67:64], VEC[i][63:32]);
      reg_rd(VEC[i][67:64], v);
      chk("R2 register readback", v, VEC[i][31:0]);
    end

    // R3 R4 R6 R7: device to memory, two descriptors, partial last word
    set_desc(0, 32'h2000, 16'd8, 1'b0);
    set_desc(1, 32'h3000, 16'd6, 1'b1);
    clear_logs(rb);
    reg_wr(4'd7, 32'h4);
    reg_wr(4'd7, 32'h5);
    wait_idle(2000, "R6 completion timeout");
    chk("R3 read count", rn, 8);
    for (int i = 0; i < 8; i++) chk("R3 descriptor read address", ra[i], 32'h1000 + 4*i);
    chk("R6 write count", wn, 36);
    chk("R4 write addr 0", wa[0], 32'h2000);
    chk("R4 write addr 1", wa[1], 32'h2004);
    chk("R4 write addr 2", wa[2], 32'h3000);
    chk("R4 write addr 3", wa[3], 32'h3004);
    for (int i = 0; i < 4; i++) chk("R4 write data", wd[i], 32'hC0DE_0000 + rb + i);
    for (int i = 0; i < 32; i++) begin
      chk("R6 completion address", wa[4+i], 32'h4000 + 4*i);
      chk("R6 completion data", wd[4+i], 32'hFFFF_FFFF);
    end
    reg_rd(4'd5, v); chk("R7 device bytes", v, 32'd14);
    reg_rd(4'd6, v); chk("R7 memory bytes", v, 32'd14);
    reg_rd(4'd3, v); chk("R3 current address", v, 32'h3008);
    reg_rd(4'd7, v); chk("R6 control after end", v, 32'h4);

    // R5: memory to device
    set_desc(0, 32'h5000, 16'd12, 1'b1);
    clear_logs(rb);
    reg_wr(4'd7, 32'h0);
    reg_wr(4'd7, 32'h1);
    wait_idle(2000, "R5 completion timeout");
    chk("R5 tx count", tn, 3);
    for (int i = 0; i < 3; i++) chk("R5 tx data", td[i], (32'h5000 + 4*i) ^ 32'h5A5A_0000);
    chk("R6 completion writes", wn, 32);
    reg_rd(4'd5, v); chk("R7 device bytes", v, 32'd12);
    reg_rd(4'd6, v); chk("R7 memory bytes", v, 32'd12);

    // R8: zero length means 65536 bytes
    set_desc(0, 32'h6000, 16'd0, 1'b1);
    clear_logs(rb);
    reg_wr(4'd7, 32'h1);
    wait_idle(120000, "R8 completion timeout");
    chk("R8 tx count", tn, 16384);
    chk("R8 first word", td[0], 32'h6000 ^ 32'h5A5A_0000);
    reg_rd(4'd5, v); chk("R8 device bytes", v, 32'h10000);
    reg_rd(4'd6, v); chk("R8 memory bytes", v, 32'h10000);

    // R9: stop while waiting for a stalled device
    rx_valid = 1'b0;
    set_desc(0, 32'h2000, 16'd8, 1'b1);
    clear_logs(rb);
    reg_wr(4'd7, 32'h4);
    reg_wr(4'd7, 32'h5);
    repeat (10) @(negedge clk);
    reg_rd(4'd7, v); chk("R9 active before stop", v, 32'hC);
    reg_wr(4'd7, 32'h6);
    reg_rd(4'd7, v); chk("R9 stop visible while active", v, 32'hE);
    @(negedge clk);
    reg_rd(4'd7, v); chk("R9 halted, stop still set", v, 32'h6);
    @(negedge clk);
    reg_rd(4'd7, v); chk("R9 stop released", v, 32'h4);
    chk("R9 no writes", wn, 0);
    rx_valid = 1'b1;

    // R10 R11: error on second descriptor word
    set_desc(0, 32'h5000, 16'd12, 1'b1);
    err_en = 1'b1; err_addr = 32'h1004;
    clear_logs(rb);
    reg_wr(4'd7, 32'h0);
    reg_wr(4'd7, 32'h1);
    wait_idle(200, "R10 halt timeout");
    reg_rd(4'd7, v); chk("R10 error set, inactive", v, 32'h10);
    chk("R10 reads before error", rn, 1);
    chk("R10 no writes", wn, 0);
    reg_wr(4'd7, 32'h1);
    repeat (4) @(negedge clk);
    reg_rd(4'd7, v); chk("R11 start ignored on error", v, 32'h10);
    chk("R11 no new reads", rn, 1);
    reg_wr(4'd7, 32'h3);
    repeat (3) @(negedge clk);
    reg_rd(4'd7, v); chk("R11 stop clears error, start dropped", v, 32'h0);
    chk("R11 start with stop ignored", rn, 1);
    err_en = 1'b0;
    clear_logs(rb);
    reg_wr(4'd7, 32'h1);
    wait_idle(2000, "R11 restart timeout");
    chk("R11 restart transfers", tn, 3);

    $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
    $finish;
  end
endmodule